// File: doc/BRIEF.md
# Single-Cycle Register-Move Processor Core

This core executes a small byte-encoded instruction set made only of data moves: register to register, constant to register, memory to register and register to memory, plus a one-byte idle instruction. Each instruction is one to ten bytes long. The core fetches, splits, decodes, executes, accesses memory, writes back and advances the program counter all within one clock period. Architectural state (program counter, register slots and data memory) changes only at the rising clock edge. Every read is combinational.

There are sixteen 64-bit register slots. Slot index 15 is reserved to mean "no register". It is never written, so it always reads as zero. Instruction memory and data memory are byte addressed, and both wrap modulo their size. While reset is held, a loader port fills both memories. Debug ports show any register slot and any 8-byte data-memory word. During reset the core issues no data-memory store, so loading is never disturbed.

Top module: `mov_core`

## Requirements
- R1: While rst_n is low the program counter reads 0 and every register slot reads 0. Execution starts at address 0 on the first rising edge after rst_n goes high.
- R2: The instruction fields are laid out as follows. The high nibble of the first byte is the opcode and its low nibble is the function code. The second byte has rA in bits 7:4 and rB in bits 3:0. The 8-byte constant is little-endian and starts at the third byte.
- R3: First byte 0x20 copies R[rA] into R[rB] and advances the PC by 2.
- R4: First byte 0x30 writes the constant into R[rB] and advances the PC by 10. The rA nibble has no effect.
- R5: First byte 0x50 loads the little-endian 8-byte word at address constant + R[rB] into R[rA] and advances the PC by 10.
- R6: First byte 0x40 stores R[rA] little-endian to address constant + R[rB] and advances the PC by 10, leaving registers unchanged. It is the only instruction that writes data memory.
- R7: Byte 0x10, and every first byte other than 0x20, 0x30, 0x40 and 0x50, is a 1-byte no-op that changes no register and no memory.
- R8: A destination index of 15 writes nothing, and slot 15 reads 0 at all times.
- R9: A value written by one instruction is visible to the very next instruction's register read.
- R10: Instruction fetch bytes and data-memory bytes wrap modulo the memory size. An instruction or a word may straddle the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_ld_we | input | 1 | Loader write strobe for instruction memory |
| imem_ld_addr | input | IMEM_AW | Loader byte address, instruction memory |
| imem_ld_byte | input | 8 | Loader byte, instruction memory |
| dmem_ld_we | input | 1 | Loader write strobe for data memory |
| dmem_ld_addr | input | DMEM_AW | Loader byte address, data memory |
| dmem_ld_byte | input | 8 | Loader byte, data memory |
| dbg_reg_idx | input | 4 | Register slot to observe |
| dbg_reg_val | output | 64 | Contents of the observed slot |
| dbg_mem_addr | input | DMEM_AW | Byte address of observed data word |
| dbg_mem_word | output | 64 | Little-endian 8-byte word at dbg_mem_addr |
| pc_o | output | 64 | Current program counter |

## Verification
The bench builds the core with the default 256-byte instruction memory and 256-byte data memory (IMEM_AW = DMEM_AW = 8). At that size the following cases are all reached within a few hundred cycles:
- a store straddling data address 255/0;
- a load whose 0x100 displacement wraps to address 0;
- a 10-byte constant move fetched across instruction address 255/0;
- the program re-running after the PC wraps.

A behavioural model steps alongside the core. On every clock it compares the PC, one rotating register slot (slot 15 included) and one rotating data word.

// File: rtl/mov_pkg.sv
package mov_pkg;
    localparam int XLEN       = 64;
    localparam int RIDX_W     = 4;
    localparam int NREGS      = 1 << RIDX_W;
    localparam int WORD_BYTES = XLEN / 8;
    localparam int MAX_ILEN   = 2 + WORD_BYTES;
    localparam int LEN_W      = 4;

    localparam logic [RIDX_W-1:0] REG_NONE = '1;

    localparam logic [7:0] OPB_NOP = 8'h10;
    localparam logic [7:0] OPB_RR  = 8'h20;
    localparam logic [7:0] OPB_IR  = 8'h30;
    localparam logic [7:0] OPB_RM  = 8'h40;
    localparam logic [7:0] OPB_MR  = 8'h50;

    typedef struct packed {
        logic [7:0]      head;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [XLEN-1:0] valc;
    } fetch_t;

    typedef struct packed {
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] dst_e;
        logic [RIDX_W-1:0] dst_m;
        logic              alu_a_imm;
        logic              alu_b_zero;
        logic              mem_we;
        logic [LEN_W-1:0]  len;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;
endpackage

// File: rtl/mov_fetch.sv
module mov_fetch
    import mov_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_byte,
    input  logic [AW-1:0] pc_idx,
    output fetch_t        fo
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] ib    [MAX_ILEN];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem_q[ld_addr] <= ld_byte;
        end
    end

    // byte taps at PC .. PC+9, wrapping inside the array
    for (genvar k = 0; k < MAX_ILEN; k++) begin : g_tap
        logic [AW-1:0] tap_idx;
        assign tap_idx = pc_idx + AW'(k);
        assign ib[k]   = mem_q[tap_idx];
    end

    always_comb begin
        fo.head = ib[0];
        fo.ra   = ib[1][7:4];
        fo.rb   = ib[1][3:0];
        for (int k = 0; k < WORD_BYTES; k++) begin
            fo.valc[8*k +: 8] = ib[2+k];
        end
    end
endmodule

// File: rtl/mov_decode.sv
module mov_decode
    import mov_pkg::*;
(
    input  logic [7:0]        head,
    input  logic [RIDX_W-1:0] ra,
    input  logic [RIDX_W-1:0] rb,
    output ctrl_t             ctrl
);
    always_comb begin
        ctrl.src_a      = ra;
        ctrl.src_b      = rb;
        ctrl.dst_e      = REG_NONE;
        ctrl.dst_m      = REG_NONE;
        ctrl.alu_a_imm  = 1'b1;
        ctrl.alu_b_zero = 1'b1;
        ctrl.mem_we     = 1'b0;
        ctrl.len        = LEN_W'(1);
        case (head)
            OPB_RR: begin
                ctrl.dst_e     = rb;
                ctrl.alu_a_imm = 1'b0;
                ctrl.len       = LEN_W'(2);
            end
            OPB_IR: begin
                ctrl.dst_e = rb;
                ctrl.len   = LEN_W'(MAX_ILEN);
            end
            OPB_RM: begin
                ctrl.alu_b_zero = 1'b0;
                ctrl.mem_we     = 1'b1;
                ctrl.len        = LEN_W'(MAX_ILEN);
            end
            OPB_MR: begin
                ctrl.alu_b_zero = 1'b0;
                ctrl.dst_m      = ra;
                ctrl.len        = LEN_W'(MAX_ILEN);
            end
            OPB_NOP: begin
                ctrl.len = LEN_W'(1);
            end
            default: begin
                ctrl.len = LEN_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/mov_regfile.sv
module mov_regfile
    import mov_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd_a_idx,
    input  logic [RIDX_W-1:0] rd_b_idx,
    input  logic [RIDX_W-1:0] dbg_idx,
    output logic [XLEN-1:0]   rd_a_val,
    output logic [XLEN-1:0]   rd_b_val,
    output logic [XLEN-1:0]   dbg_val,
    input  logic [RIDX_W-1:0] wr_e_idx,
    input  logic [XLEN-1:0]   wr_e_val,
    input  logic [RIDX_W-1:0] wr_m_idx,
    input  logic [XLEN-1:0]   wr_m_val
);
    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_e_idx != REG_NONE) begin
            regs_d[wr_e_idx] = wr_e_val;
        end
        if (wr_m_idx != REG_NONE) begin
            regs_d[wr_m_idx] = wr_m_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a_val = regs_q[rd_a_idx];
    assign rd_b_val = regs_q[rd_b_idx];
    assign dbg_val  = regs_q[dbg_idx];
endmodule

// File: rtl/mov_dmem.sv
module mov_dmem
    import mov_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [7:0]      ld_byte,
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    input  logic [AW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_word
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] widx  [WORD_BYTES];
    logic [AW-1:0] didx  [WORD_BYTES];

    always_comb begin
        for (int k = 0; k < WORD_BYTES; k++) begin
            widx[k]          = addr + AW'(k);
            didx[k]          = dbg_addr + AW'(k);
            rdata[8*k +: 8]  = mem_q[widx[k]];
            dbg_word[8*k +: 8] = mem_q[didx[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem_q[ld_addr] <= ld_byte;
        end
        if (we) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                mem_q[widx[k]] <= wdata[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/mov_core.sv
module mov_core
    import mov_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_ld_we,
    input  logic [IMEM_AW-1:0] imem_ld_addr,
    input  logic [7:0]         imem_ld_byte,
    input  logic               dmem_ld_we,
    input  logic [DMEM_AW-1:0] dmem_ld_addr,
    input  logic [7:0]         dmem_ld_byte,
    input  logic [3:0]         dbg_reg_idx,
    output logic [63:0]        dbg_reg_val,
    input  logic [DMEM_AW-1:0] dbg_mem_addr,
    output logic [63:0]        dbg_mem_word,
    output logic [63:0]        pc_o
);
    core_state_t     st_d, st_q;
    fetch_t          fo;
    ctrl_t           ctrl;
    logic [XLEN-1:0] val_a, val_b, val_e, val_m;
    logic [XLEN-1:0] alu_a, alu_b;
    logic            store_en;

    // fetch: split bytes at the PC
    mov_fetch #(.AW(IMEM_AW)) u_fetch (
        .clk     (clk),
        .ld_we   (imem_ld_we),
        .ld_addr (imem_ld_addr),
        .ld_byte (imem_ld_byte),
        .pc_idx  (st_q.pc[IMEM_AW-1:0]),
        .fo      (fo)
    );

    // decode: lengths, selects, destinations, store enable
    mov_decode u_decode (
        .head (fo.head),
        .ra   (fo.ra),
        .rb   (fo.rb),
        .ctrl (ctrl)
    );

    mov_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ctrl.src_a),
        .rd_b_idx (ctrl.src_b),
        .dbg_idx  (dbg_reg_idx),
        .rd_a_val (val_a),
        .rd_b_val (val_b),
        .dbg_val  (dbg_reg_val),
        .wr_e_idx (ctrl.dst_e),
        .wr_e_val (val_e),
        .wr_m_idx (ctrl.dst_m),
        .wr_m_val (val_m)
    );

    // execute: single adder fed by two operand muxes
    always_comb begin
        alu_a = ctrl.alu_a_imm  ? fo.valc : val_a;
        alu_b = ctrl.alu_b_zero ? '0      : val_b;
        val_e = alu_a + alu_b;
    end

    // no store may disturb the loader while reset is held
    assign store_en = ctrl.mem_we & rst_n;

    mov_dmem #(.AW(DMEM_AW)) u_dmem (
        .clk      (clk),
        .ld_we    (dmem_ld_we),
        .ld_addr  (dmem_ld_addr),
        .ld_byte  (dmem_ld_byte),
        .addr     (val_e[DMEM_AW-1:0]),
        .we       (store_en),
        .wdata    (val_a),
        .rdata    (val_m),
        .dbg_addr (dbg_mem_addr),
        .dbg_word (dbg_mem_word)
    );

    // PC update
    always_comb begin
        st_d    = st_q;
        st_d.pc = st_q.pc + XLEN'(ctrl.len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;
endmodule

// File: rtl/mov_core_chk.sv
module mov_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] pc,
    input logic [7:0]  head,
    input logic        dm_we,
    input logic [3:0]  dst_e,
    input logic [3:0]  dst_m,
    input logic [3:0]  dbg_idx,
    input logic [63:0] dbg_val
);
    p_reset_pc_r1: assert property (@(posedge clk) !rst_n |=> (pc == 64'd0));

    p_step_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head == 8'h20) |=> (pc == $past(pc) + 64'd2));

    p_step_ten_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (head == 8'h30 || head == 8'h40 || head == 8'h50) |=> (pc == $past(pc) + 64'd10));

    p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(head == 8'h20 || head == 8'h30 || head == 8'h40 || head == 8'h50)
        |=> (pc == $past(pc) + 64'd1));

    p_store_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> (head == 8'h40));

    p_single_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((dst_e != 4'hF) && (dst_m != 4'hF)));

    p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_idx == 4'hF) |-> (dbg_val == 64'd0));
endmodule

bind mov_core mov_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc_o),
    .head    (fo.head),
    .dm_we   (store_en),
    .dst_e   (ctrl.dst_e),
    .dst_m   (ctrl.dst_m),
    .dbg_idx (dbg_reg_idx),
    .dbg_val (dbg_reg_val)
);

// File: tb/mov_core_test.sv
`timescale 1ns/100ps
module mov_core_test;
    localparam int IAW = 8;
    localparam int DAW = 8;
    localparam int IDEPTH = 1 << IAW;
    localparam int DDEPTH = 1 << DAW;
    localparam int RUN_CYCLES = 520;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           imem_ld_we = 1'b0;
    logic [IAW-1:0] imem_ld_addr = '0;
    logic [7:0]     imem_ld_byte = '0;
    logic           dmem_ld_we = 1'b0;
    logic [DAW-1:0] dmem_ld_addr = '0;
    logic [7:0]     dmem_ld_byte = '0;
    logic [3:0]     dbg_reg_idx = '0;
    logic [63:0]    dbg_reg_val;
    logic [DAW-1:0] dbg_mem_addr = '0;
    logic [63:0]    dbg_mem_word;
    logic [63:0]    pc_o;

    always #2.5 clk = ~clk;

    mov_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) uut (
        .clk(clk), .rst_n(rst_n),
        .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_byte(imem_ld_byte),
        .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_byte(dmem_ld_byte),
        .dbg_reg_idx(dbg_reg_idx), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_word(dbg_mem_word),
        .pc_o(pc_o)
    );

    // reference state
    logic [7:0]  im_m [IDEPTH];
    logic [7:0]  dm_m [DDEPTH];
    logic [63:0] rg_m [16];
    logic [63:0] pc_m;
    int          wp;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;
    string       last_tag;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        im_m[wp % IDEPTH] = b;
        wp++;
    endtask

    task automatic put_word(input logic [63:0] v);
        for (int k = 0; k < 8; k++) put(v[8*k +: 8]);
    endtask

    task automatic op_rr(input logic [3:0] a, input logic [3:0] b);
        put(8'h20); put({a, b});
    endtask

    task automatic op_ir(input logic [3:0] afield, input logic [3:0] b, input logic [63:0] v);
        put(8'h30); put({afield, b}); put_word(v);
    endtask

    task automatic op_rm(input logic [3:0] a, input logic [3:0] b, input logic [63:0] d);
        put(8'h40); put({a, b}); put_word(d);
    endtask

    task automatic op_mr(input logic [3:0] a, input logic [3:0] b, input logic [63:0] d);
        put(8'h50); put({a, b}); put_word(d);
    endtask

    function automatic logic [7:0] ib(input logic [63:0] addr);
        return im_m[addr[IAW-1:0]];
    endfunction

    function automatic logic [63:0] dword(input logic [63:0] addr);
        logic [63:0] w;
        logic [63:0] a;
        for (int k = 0; k < 8; k++) begin
            a = addr + 64'(k);
            w[8*k +: 8] = dm_m[a[DAW-1:0]];
        end
        return w;
    endfunction

    // one instruction of the behavioural model
    task automatic model_step();
        logic [7:0]  op;
        logic [3:0]  ra, rb;
        logic [63:0] c, ea, va, vb, a;
        op = ib(pc_m);
        ra = ib(pc_m + 1)[7:4];
        rb = ib(pc_m + 1)[3:0];
        for (int k = 0; k < 8; k++) c[8*k +: 8] = ib(pc_m + 64'(2 + k));
        va = rg_m[ra];
        vb = rg_m[rb];
        ea = c + vb;
        case (op)
            8'h20: begin last_tag = "R3"; if (rb != 4'hF) rg_m[rb] = va; pc_m += 2; end
            8'h30: begin last_tag = "R4"; if (rb != 4'hF) rg_m[rb] = c; pc_m += 10; end
            8'h40: begin
                last_tag = "R6";
                for (int k = 0; k < 8; k++) begin
                    a = ea + 64'(k);
                    dm_m[a[DAW-1:0]] = va[8*k +: 8];
                end
                pc_m += 10;
            end
            8'h50: begin last_tag = "R5"; if (ra != 4'hF) rg_m[ra] = dword(ea); pc_m += 10; end
            default: begin last_tag = "R7"; pc_m += 1; end
        endcase
        if ((op == 8'h30 || op == 8'h40 || op == 8'h50) && ((pc_m - 10) % IDEPTH) > (IDEPTH - 10))
            last_tag = "R10";
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < IDEPTH; i++) im_m[i] = 8'h00;
        for (int i = 0; i < DDEPTH; i++) dm_m[i] = 8'((i * 37 + 5) & 255);
        for (int i = 0; i < 16; i++) rg_m[i] = 64'd0;
        pc_m = 64'd0;
        last_tag = "R1";

        // program: byte layout per R2
        wp = 0;
        put(8'h10); put(8'h10); put(8'h10); put(8'h10);
        op_ir(4'hF, 4'd1, 64'h1122_3344_5566_7788);   // R4
        op_ir(4'hF, 4'd2, 64'h0000_0000_0000_00F0);
        op_ir(4'hF, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        op_rr(4'd1, 4'd4);                             // R3
        op_rr(4'd4, 4'd5);                             // R9 chained read
        op_rm(4'd1, 4'd2, 64'd8);                      // R6 at 248
        op_rm(4'd3, 4'd2, 64'd12);                     // R10 straddles 255/0
        op_mr(4'd6, 4'd2, 64'd8);                      // R5
        op_mr(4'd7, 4'hF, 64'h100);                    // R10 wraps to 0
        op_rr(4'd1, 4'hF);                             // R8
        op_ir(4'hF, 4'hF, 64'd5);                      // R8
        op_ir(4'd2, 4'd8, 64'hDEAD_BEEF_0BAD_F00D);    // R4 rA ignored
        put(8'h00); put(8'h21); put(8'hFF); put(8'h35); // R7 odd bytes
        op_mr(4'hF, 4'd2, 64'd0);                      // R8 load to none
        op_rm(4'hF, 4'hF, 64'd16);                     // store zero at 16
        op_rr(4'd7, 4'd9);
        // constant move fetched across the top of instruction memory
        wp = IDEPTH - 6;
        put(8'h30); put(8'hFA);
        put(8'hA1); put(8'hB2); put(8'hC3); put(8'hD4);

        // load both memories under reset
        for (int i = 0; i < IDEPTH; i++) begin
            @(negedge clk);
            imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_byte = im_m[i];
            dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_byte = dm_m[i];
        end
        @(negedge clk);
        imem_ld_we = 1'b0;
        dmem_ld_we = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 pc in reset", pc_o, 64'd0);
        for (int i = 0; i < 16; i++) begin
            dbg_reg_idx = 4'(i);
            #0.5;
            chk("R1 register in reset", dbg_reg_val, 64'd0);
        end
        rst_n = 1'b1;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            chk({last_tag, " R2 pc"}, pc_o, pc_m);
            dbg_reg_idx  = 4'(cyc % 16);
            dbg_mem_addr = DAW'((cyc % (DDEPTH / 8)) * 8);
            #0.5;
            if (dbg_reg_idx == 4'hF)
                chk("R8 slot none", dbg_reg_val, 64'd0);
            else
                chk({last_tag, " R2 R9 register"}, dbg_reg_val, rg_m[dbg_reg_idx]);
            if (dbg_mem_addr == '0 || dbg_mem_addr == DAW'(DDEPTH - 8))
                chk("R10 data word", dbg_mem_word, dword(64'(dbg_mem_addr)));
            else
                chk("R6 data word", dbg_mem_word, dword(64'(dbg_mem_addr)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule